// File: doc/BRIEF.md
# Center-Aligned Event PWM Timer

This block is a PWM timer built around one up/down counter. The counter climbs from zero to an active period value and then descends back to zero, so one full PWM cycle lasts twice the period value. Each output lane owns a compare value. When the counter equals that value, the lane fires an event. The event drives the lane's output high while the counter rises and low while it falls, so every pulse is centred on the counter's peak. The duty cycle is `(period - match) / period`, and a match of half the period gives a 50% square wave.

Software writes the period and compare values into shadow registers. Those values move into the active copies only while the counter sits at zero, so an update never cuts a cycle short. One extra lane drives a separate sync output. Its default compare value puts its edge a quarter of a cycle after the cycle starts, which makes it usable to line up another timer. Every event sets a sticky flag, and software clears a flag by writing a one to it. An enable mask selects which flags raise the interrupt.

The counter leaves reset halted. Output levels may be forced through the register port only while the counter is halted.

Top module: `center_pwm`

## Requirements
- R1: After reset:
  - the counter is halted at zero and every output is low;
  - the flags, interrupt enables and resolution fields are zero, and direction reversal is enabled on every output;
  - the period reload holds `DEF_PERIOD` and every match reload holds `DEF_PERIOD/2`.
- R2: While running, the counter steps by one per clock from 0 up to the active period P, then down to 0, and repeats, for a cycle of 2P clocks. While halted, the counter holds its value.
- R3: With direction reversal enabled, a lane whose active match M satisfies 0 < M < P behaves as follows:
  - its output rises in the clock after the counter reads M on the way up;
  - its output falls in the clock after the counter reads M on the way down;
  - it is therefore high for 2(P-M) clocks per cycle, centred on the counter's peak.
- R4: With direction reversal disabled on an output, a match event sets that output whatever the count direction, and running never clears it.
- R5: A match at a turning point (count 0 or count P) requests set and clear together. The output's 2-bit resolution field then decides the result: 00 no change, 01 set, 10 clear, 11 toggle.
- R6: The period reload and the match reloads are copied into the active values only on a clock in which the counter reads 0. This includes clocks while halted at 0.
- R7: The sync lane follows the same rules on its own output. With default values it rises a quarter of the full cycle after the cycle starts.
- R8: Flag bit 0 is set when the running counter reads P, bit i+1 by a match on lane i, and bit NCH+1 by the sync lane. Flags are sticky. Writing ones to them clears them, and an event in the same clock wins over the clear.
- R9: `irq_o` is high exactly when some flag is set whose bit is also set in the interrupt enable register.
- R10: A write to the output register loads every output level while halted. The same write is ignored while running. Control bit 0 = 1 halts the counter and 0 runs it.
- R11: Register addresses:
  - 0: control (bit 0 halt)
  - 1: period reload
  - 2: flags
  - 3: interrupt enable
  - 4: output levels (bit i lane i, bit NCH sync)
  - 5: direction-reversal enable, one bit per output
  - 6: resolution (bits 2i+1:2i for output i)
  - 16+i: match reload for lane i, with 16+NCH for the sync lane

  Reads return the written reload values and the current flags and outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| pwm_o | output | NCH | PWM lane outputs |
| sync_o | output | 1 | Sync lane output |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps every match value from 0 to P for small periods, under all four resolution codes. A design that treated the turning points as plain up or down counts would leave an output stuck high or low at M=0 and M=P, or would never toggle. Match and period writes are placed in the middle of a cycle. A design that loaded them at once would shift an edge inside the current cycle. Flag clears are timed to land on an event. The bench also halts the counter at a nonzero count, forces outputs, writes outputs while running, and then resumes. A wrong design would drop the event, honour the running write, or restart the counter from zero.

// File: rtl/center_pwm_pkg.sv
package center_pwm_pkg;

    typedef enum logic [1:0] {
        RES_KEEP   = 2'b00,
        RES_SET    = 2'b01,
        RES_CLEAR  = 2'b10,
        RES_TOGGLE = 2'b11
    } res_mode_e;

    localparam int unsigned ADR_CTRL       = 0;
    localparam int unsigned ADR_PERIOD     = 1;
    localparam int unsigned ADR_FLAGS      = 2;
    localparam int unsigned ADR_IRQEN      = 3;
    localparam int unsigned ADR_OUTS       = 4;
    localparam int unsigned ADR_REVEN      = 5;
    localparam int unsigned ADR_RESOLVE    = 6;
    localparam int unsigned ADR_MATCH_BASE = 16;

endpackage

// File: rtl/cpwm_updown.sv
module cpwm_updown #(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned DEF_PERIOD = 3750
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] per_sh_i,
    output logic [CNT_W-1:0] count_o,
    output logic             up_o,
    output logic [CNT_W-1:0] per_o,
    output logic             limit_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             up;
        logic [CNT_W-1:0] per;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // active period follows the reload only at the zero point
        if (st_q.count == '0) st_d.per = per_sh_i;
        if (run_i) begin
            if (st_q.up) begin
                if (st_q.count >= st_q.per) begin
                    st_d.up = 1'b0;
                    if (st_q.count != '0) st_d.count = st_q.count - ONE;
                end else begin
                    st_d.count = st_q.count + ONE;
                end
            end else if (st_q.count == '0) begin
                st_d.up = 1'b1;
                if (st_q.per != '0) st_d.count = ONE;
            end else begin
                st_d.count = st_q.count - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{count: '0, up: 1'b1, per: CNT_W'(DEF_PERIOD)};
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign up_o    = st_q.up;
    assign per_o   = st_q.per;
    assign limit_o = run_i && (st_q.count == st_q.per);

    a_r2_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(st_q.count));
    a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && st_q.up && (st_q.count < st_q.per) |=> st_q.count == $past(st_q.count) + ONE);
    a_r2_turn_down: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && st_q.up && (st_q.count == st_q.per) && (st_q.count != '0)
        |=> !st_q.up && (st_q.count == $past(st_q.count) - ONE));
    a_r6_period_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.per) |-> $past(st_q.count) == '0);
endmodule

// File: rtl/cpwm_lane.sv
module cpwm_lane
    import center_pwm_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned DEF_MATCH = 1875
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             up_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_val_i,
    input  logic             force_i,
    input  logic             force_val_i,
    input  logic             rev_i,
    input  logic [1:0]       res_i,
    output logic             hit_o,
    output logic             out_o,
    output logic [CNT_W-1:0] shadow_o
);
    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
        logic             out;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     turn, set_req, clr_req;

    always_comb begin
        hit_o   = run_i && (count_i == st_q.active);
        turn    = (count_i == '0) || (count_i == per_i);
        set_req = hit_o && (!rev_i || up_i || turn);
        clr_req = hit_o && rev_i && (!up_i || turn);
        st_d    = st_q;
        if (count_i == '0) st_d.active = st_q.shadow;
        if (wr_i)          st_d.shadow = wr_val_i;
        if (set_req && clr_req) begin
            case (res_mode_e'(res_i))
                RES_KEEP:   st_d.out = st_q.out;
                RES_SET:    st_d.out = 1'b1;
                RES_CLEAR:  st_d.out = 1'b0;
                RES_TOGGLE: st_d.out = !st_q.out;
            endcase
        end else if (set_req) begin
            st_d.out = 1'b1;
        end else if (clr_req) begin
            st_d.out = 1'b0;
        end else if (!run_i && force_i) begin
            st_d.out = force_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{shadow: CNT_W'(DEF_MATCH), active: CNT_W'(DEF_MATCH), out: 1'b0};
        else        st_q <= st_d;
    end

    assign out_o    = st_q.out;
    assign shadow_o = st_q.shadow;

    a_r6_match_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.active) |-> $past(count_i) == '0);
    a_r10_out_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.out) |-> $past(hit_o) || ($past(force_i) && !$past(run_i)));
    a_r5_keep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        set_req && clr_req && (res_i == 2'b00) |=> $stable(st_q.out));
    a_r4_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && !rev_i && st_q.out |=> st_q.out);
endmodule

// File: rtl/center_pwm.sv
module center_pwm
    import center_pwm_pkg::*;
#(
    parameter int unsigned NCH        = 4,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned DEF_PERIOD = 3750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    pwm_o,
    output logic              sync_o,
    output logic              irq_o
);
    localparam int unsigned NOUT      = NCH + 1;
    localparam int unsigned NEV       = NCH + 2;
    localparam int unsigned DEF_MATCH = DEF_PERIOD / 2;

    typedef struct packed {
        logic             halt;
        logic [CNT_W-1:0] per_sh;
        logic [NEV-1:0]   flags;
        logic [NEV-1:0]   ien;
        logic [NOUT-1:0]  rev;
        logic [2*NOUT-1:0] res;
    } regs_t;

    regs_t            rg_d, rg_q;
    logic             run;
    logic [CNT_W-1:0] count, per_act;
    logic             up, limit;
    logic [NOUT-1:0]  hits, outs;
    logic [NEV-1:0]   events, flag_clr;
    logic [CNT_W-1:0] shadow [NOUT];
    logic             unused_wr;

    assign run       = !rg_q.halt;
    assign unused_wr = ^wr_data;

    function automatic logic sel(input logic [ADDR_W-1:0] a, input int unsigned target);
        return wr_en && (a == ADDR_W'(target));
    endfunction

    cpwm_updown #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(run), .per_sh_i(rg_q.per_sh),
        .count_o(count), .up_o(up), .per_o(per_act), .limit_o(limit)
    );

    for (genvar i = 0; i < NOUT; i++) begin : g_lane
        localparam int unsigned MADR = ADR_MATCH_BASE + i;
        cpwm_lane #(.CNT_W(CNT_W), .DEF_MATCH(DEF_MATCH)) u_lane (
            .clk(clk), .rst_n(rst_n), .run_i(run), .count_i(count), .up_i(up),
            .per_i(per_act), .wr_i(sel(wr_addr, MADR)), .wr_val_i(wr_data[CNT_W-1:0]),
            .force_i(sel(wr_addr, ADR_OUTS)), .force_val_i(wr_data[i]),
            .rev_i(rg_q.rev[i]), .res_i(rg_q.res[2*i +: 2]),
            .hit_o(hits[i]), .out_o(outs[i]), .shadow_o(shadow[i])
        );
    end

    assign events = {hits, limit};

    always_comb begin
        rg_d     = rg_q;
        flag_clr = sel(wr_addr, ADR_FLAGS) ? wr_data[NEV-1:0] : '0;
        if (sel(wr_addr, ADR_CTRL))    rg_d.halt   = wr_data[0];
        if (sel(wr_addr, ADR_PERIOD))  rg_d.per_sh = wr_data[CNT_W-1:0];
        if (sel(wr_addr, ADR_IRQEN))   rg_d.ien    = wr_data[NEV-1:0];
        if (sel(wr_addr, ADR_REVEN))   rg_d.rev    = wr_data[NOUT-1:0];
        if (sel(wr_addr, ADR_RESOLVE)) rg_d.res    = wr_data[2*NOUT-1:0];
        rg_d.flags = (rg_q.flags & ~flag_clr) | events;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '{halt: 1'b1, per_sh: CNT_W'(DEF_PERIOD), flags: '0,
                              ien: '0, rev: '1, res: '0};
        else        rg_q <= rg_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(ADR_CTRL):    rd_data = DATA_W'(rg_q.halt);
            ADDR_W'(ADR_PERIOD):  rd_data = DATA_W'(rg_q.per_sh);
            ADDR_W'(ADR_FLAGS):   rd_data = DATA_W'(rg_q.flags);
            ADDR_W'(ADR_IRQEN):   rd_data = DATA_W'(rg_q.ien);
            ADDR_W'(ADR_OUTS):    rd_data = DATA_W'(outs);
            ADDR_W'(ADR_REVEN):   rd_data = DATA_W'(rg_q.rev);
            ADDR_W'(ADR_RESOLVE): rd_data = DATA_W'(rg_q.res);
            default: begin
                for (int i = 0; i < NOUT; i++)
                    if (rd_addr == ADDR_W'(ADR_MATCH_BASE + i)) rd_data = DATA_W'(shadow[i]);
            end
        endcase
    end

    assign pwm_o  = outs[NCH-1:0];
    assign sync_o = outs[NCH];
    assign irq_o  = |(rg_q.flags & rg_q.ien);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rg_q.flags) & ~$past(flag_clr) & ~rg_q.flags) == '0);
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(events) & ~rg_q.flags) == '0);
    a_r10_halt_no_events: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.halt |-> events == '0);
endmodule

// File: tb/tb_center_pwm.sv
`timescale 1ns/1ps
module tb_center_pwm;
    localparam int NCH = 4;
    localparam int NOUT = NCH + 1;
    localparam int NEV = NCH + 2;
    localparam int DEFP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0] rd_addr = 5'd2;
    logic [15:0] rd_data;
    logic [NCH-1:0] pwm_o;
    logic sync_o, irq_o;

    int checks = 0;
    int fails = 0;

    // reference state derived from the requirements
    int m_cnt, m_up, m_per, m_shper, m_run, m_flags, m_ien, m_rev;
    int m_act[NOUT];
    int m_sh[NOUT];
    int m_res[NOUT];
    int m_out[NOUT];

    always #2 clk = ~clk;

    center_pwm #(.NCH(NCH), .CNT_W(8), .DATA_W(16), .ADDR_W(5), .DEF_PERIOD(DEFP)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o), .sync_o(sync_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_up = 1; m_per = DEFP; m_shper = DEFP; m_run = 0;
        m_flags = 0; m_ien = 0; m_rev = (1 << NOUT) - 1;
        for (int i = 0; i < NOUT; i++) begin
            m_act[i] = DEFP / 2; m_sh[i] = DEFP / 2; m_res[i] = 0; m_out[i] = 0;
        end
    endtask

    task automatic model_edge(input bit we, input int wa, input int wd);
        int c0, ev, clrm;
        bit turn, s, c;
        c0 = m_cnt; ev = 0; clrm = 0;
        if (m_run != 0) begin
            for (int i = 0; i < NOUT; i++) begin
                if (c0 == m_act[i]) begin
                    turn = (c0 == 0) || (c0 == m_per);
                    s = !m_rev[i] || (m_up != 0) || turn;
                    c = m_rev[i] && ((m_up == 0) || turn);
                    ev |= 1 << (i + 1);
                    if (s && c) begin
                        case (m_res[i])
                            1: m_out[i] = 1;
                            2: m_out[i] = 0;
                            3: m_out[i] = 1 - m_out[i];
                            default: ;
                        endcase
                    end else if (s) m_out[i] = 1;
                    else if (c) m_out[i] = 0;
                end
            end
            if (c0 == m_per) ev |= 1;
            if (m_up != 0) begin
                if (c0 >= m_per) begin m_up = 0; if (c0 != 0) m_cnt = c0 - 1; end
                else m_cnt = c0 + 1;
            end else if (c0 == 0) begin
                m_up = 1; if (m_per != 0) m_cnt = 1;
            end else m_cnt = c0 - 1;
        end else if (we && wa == 4) begin
            for (int i = 0; i < NOUT; i++) m_out[i] = (wd >> i) & 1;
        end
        if (we && wa == 2) clrm = wd;
        m_flags = ((m_flags & ~clrm) | ev) & ((1 << NEV) - 1);
        if (c0 == 0) begin
            m_per = m_shper;
            for (int i = 0; i < NOUT; i++) m_act[i] = m_sh[i];
        end
        if (we) begin
            case (wa)
                0: m_run = ((wd & 1) == 0) ? 1 : 0;
                1: m_shper = wd & 255;
                3: m_ien = wd & ((1 << NEV) - 1);
                5: m_rev = wd & ((1 << NOUT) - 1);
                6: for (int i = 0; i < NOUT; i++) m_res[i] = (wd >> (2 * i)) & 3;
                default: if (wa >= 16 && wa < 16 + NOUT) m_sh[wa - 16] = wd & 255;
            endcase
        end
    endtask

    // one clock: drive a write for the coming edge, then compare after it
    task automatic step(input bit we, input int wa, input int wd, input string tag);
        int pw;
        wr_en = we; wr_addr = wa[4:0]; wr_data = wd[15:0];
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        model_edge(we, wa, wd);
        pw = 0;
        for (int i = 0; i < NCH; i++) pw |= m_out[i] << i;
        chk({tag, " pwm"}, int'(pwm_o), pw);
        chk({tag, " sync R7"}, int'(sync_o), m_out[NCH]);
        chk("R8 flags", int'(rd_data), m_flags);
        chk("R9 irq", int'(irq_o), ((m_flags & m_ien) != 0) ? 1 : 0);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(0, 0, 0, tag);
    endtask

    task automatic rdchk(input int a, input int exp, input string tag);
        rd_addr = a[4:0];
        #1;
        chk(tag, int'(rd_data), exp);
        rd_addr = 5'd2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int mv, ienv;
        do_reset();
        // R1: reset state
        chk("R1 pwm", int'(pwm_o), 0);
        chk("R1 sync", int'(sync_o), 0);
        chk("R1 irq", int'(irq_o), 0);
        rdchk(0, 1, "R1 halt");
        rdchk(1, DEFP, "R1 period");
        rdchk(2, 0, "R1 flags");
        rdchk(5, (1 << NOUT) - 1, "R1 reversal");
        for (int i = 0; i < NOUT; i++) rdchk(16 + i, DEFP / 2, "R1 match");

        // R7: default values, sync rises a quarter cycle in
        step(1, 0, 0, "R7 start");
        idle(4 * DEFP + 4, "R7 R3 default");

        // R2 R3 R5 R8 R9: sweep every match value and every resolution code
        for (int p = 2; p <= 7; p++) begin
            for (int base = 0; base <= p; base += NOUT) begin
                for (int rm = 0; rm < 4; rm++) begin
                    do_reset();
                    step(1, 1, p, "R2 setup");
                    for (int i = 0; i < NOUT; i++) begin
                        mv = (base + i > p) ? p : base + i;
                        step(1, 16 + i, mv, "R3 setup");
                    end
                    step(1, 6, rm * 341, "R5 setup");
                    ienv = (rm == 0) ? 63 : (rm == 1) ? 1 : (rm == 2) ? 0 : 2;
                    step(1, 3, ienv, "R9 setup");
                    step(1, 0, 0, "R2 start");
                    for (int k = 0; k < 4 * p + 6; k++) begin
                        if (k == p + 1) step(1, 2, 16'hFFFF, "R8 clear");
                        else step(0, 0, 0, "R2 R3 R5 sweep");
                    end
                end
            end
        end

        // R4: direction reversal disabled on lanes 1 and 3
        do_reset();
        step(1, 1, 6, "R4 setup");
        step(1, 16, 1, "R4 setup"); step(1, 17, 2, "R4 setup");
        step(1, 18, 3, "R4 setup"); step(1, 19, 5, "R4 setup");
        step(1, 5, 5'b10101, "R4 setup");
        step(1, 0, 0, "R4 start");
        idle(30, "R4");

        // R6: reload values written mid-cycle wait for the zero point
        do_reset();
        step(1, 1, 6, "R6 setup");
        step(1, 16, 3, "R6 setup");
        step(1, 0, 0, "R6 start");
        idle(3, "R6");
        step(1, 16, 1, "R6 match write");
        idle(4, "R6");
        step(1, 1, 4, "R6 period write");
        step(1, 17, 2, "R6 match write");
        idle(40, "R6");

        // R10: forcing outputs only works while halted
        do_reset();
        step(1, 1, 5, "R10 setup");
        step(1, 0, 0, "R10 start");
        idle(7, "R10");
        step(1, 4, 5'h1F, "R10 write running");
        idle(2, "R10");
        step(1, 0, 1, "R10 halt");
        idle(3, "R10 halted");
        step(1, 4, 5'h0A, "R10 force");
        idle(2, "R10 halted");
        step(1, 4, 5'h15, "R10 force");
        step(1, 0, 0, "R10 resume");
        idle(20, "R10");

        // R11: register readback
        step(1, 17, 3, "R11 write");
        rdchk(17, 3, "R11 match readback");
        step(1, 6, 10'h2C6, "R11 write");
        rdchk(6, 10'h2C6, "R11 resolve readback");
        step(1, 3, 6'h21, "R11 write");
        rdchk(3, 6'h21, "R11 irq enable readback");
        rdchk(1, 5, "R11 period readback");
        rdchk(0, 0, "R11 control readback");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule